// File: doc/BRIEF.md
# SPI Slave with Transmit and Receive FIFOs

This block is a byte-oriented SPI slave for a system-clock domain. An external master selects it with an active-low select line and clocks 8-bit frames in mode 0. The master samples on the rising SCK edge, and data changes on the falling edge. In each frame, one byte arrives on MOSI while another byte leaves on MISO, most significant bit first. SCK, MOSI and select are brought into the system clock through two-flop synchronisers. All edge detection happens on the synchronised copies, so the system clock must run at least four times faster than SCK.

The host side is a small word-addressed register port. The host fills a 16-entry transmit FIFO and drains a 16-entry receive FIFO. After every frame the slave does a short housekeeping pass of two system clocks. It pushes the received byte, pops the next transmit byte into the shift register and clears the bit counter. If no transmit byte is waiting, the slave raises a flag and ignores the master until the host writes more data. It then loads the new byte by itself.

Sticky interrupt flags record three events: a stored byte, a starved transmitter and a receive overrun. The host clears a flag by writing 1 to its bit. A global enable gates the flags onto one interrupt output.

Top module: `spiByteSlave`

## Requirements
- R1: After reset the register port reads the following: control (address 0) = 0x00, status (address 1) = 0x05, flags (address 2) = 0x00. The interrupt output is low. Status bits: bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full.
- R2: With enable (control bit0) and slave mode (control bit1) both set and select low, each frame of 8 rising SCK edges works as follows. The MOSI byte, MSB first, is pushed into the receive FIFO. The loaded transmit byte is presented on MISO, MSB first, before each rising edge.
- R3: While select is high, no SCK edge shifts data. If select rises in the middle of a frame, the partial bits are discarded, no byte is stored and the same transmit byte is presented again on the next frame.
- R4: If enable or slave mode is clear, SCK edges are ignored and nothing is loaded from the transmit FIFO.
- R5: Consecutive frames transmit the transmit-FIFO bytes in write order. Received bytes are read from address 3 in arrival order. Each host read of address 3 pops one byte.
- R6: If a frame ends with the transmit FIFO empty, flag bit0 (starved) sets. Later frames are ignored until the host writes address 3, and the written byte is then loaded automatically.
- R7: Each FIFO holds 16 bytes. A write to address 3 while the transmit FIFO is full is dropped.
- R8: If a frame completes while the receive FIFO is full, the byte is dropped, flag bit1 (overrun) sets and the stored bytes are kept. A stored frame sets flag bit2.
- R9: Flags are sticky and are cleared by writing 1 to their bit at address 2. The interrupt output is high exactly when control bit2 (global interrupt enable) is set and some flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the master |
| mosiIn | input | 1 | Serial data from the master |
| csnIn | input | 1 | Active-low slave select |
| misoOut | output | 1 | Serial data to the master |
| regAddr | input | 2 | Register word address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops receive FIFO at address 3) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench aborts a frame by raising select after three bits. A design that kept the counter or the shifted byte would store garbage and shift the following transmit byte out misaligned. The bench also clocks frames while the slave is disabled and while it is starved. A slave that ignored the enable or the halt would store bytes that the scoreboard does not expect.

The bench writes seventeen bytes into the transmit FIFO, then runs sixteen frames to fill the receive FIFO and one more frame. This checks that the seventeenth write is dropped and never appears on MISO. It also checks that the overflowing frame sets the overrun flag without corrupting the sixteen stored bytes. Finally, the bench clears the flags and toggles the global interrupt enable, which exposes an interrupt that ignores its gate or flags that clear themselves.

// File: rtl/spiSlavePkg.sv
package spiSlavePkg;
  // control to datapath strobes, at most one active per cycle
  typedef struct packed {
    logic sample;   // capture MOSI bit
    logic shift;    // advance MISO shift register
    logic restore;  // reload shift register from held byte
    logic load;     // pop transmit FIFO into shift register
    logic store;    // push received byte
    logic starve;   // frame ended with nothing to send
  } spiStrobes_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  localparam int FLAG_STARVE  = 0;
  localparam int FLAG_OVERRUN = 1;
  localparam int FLAG_STORED  = 2;
endpackage

// File: rtl/spiSlaveFifo.sv
module spiSlaveFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign dout  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/spiSlaveCtrl.sv
module spiSlaveCtrl
  import spiSlavePkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        mosiIn,
  input  logic        csnIn,
  input  logic        active,
  input  logic        txEmpty,
  output logic        mosiBit,
  output spiStrobes_t strb
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  typedef enum logic [1:0] {IDLE, READY, STORE, RELOAD} ctrlState_t;

  logic [SYNC_STAGES-1:0] sckSync, mosiSync, csnSync;
  logic sckS, csnS, sckPrev, rise, fall, selected;
  ctrlState_t state, nextState;
  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      csnSync  <= '1;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      csnSync  <= {csnSync[SYNC_STAGES-2:0], csnIn};
      sckPrev  <= sckS;
    end
  end

  assign sckS     = sckSync[SYNC_STAGES-1];
  assign csnS     = csnSync[SYNC_STAGES-1];
  assign mosiBit  = mosiSync[SYNC_STAGES-1];
  assign rise     = sckS && !sckPrev;
  assign fall     = !sckS && sckPrev;
  assign selected = active && !csnS;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      IDLE: if (active && !txEmpty) begin
        strb.load = 1'b1;
        nextState = READY;
      end
      READY: begin
        if (!selected) begin
          strb.restore = 1'b1;
        end else if (rise) begin
          strb.sample = 1'b1;
          if (bitCnt == LAST) nextState = STORE;
        end else if (fall && bitCnt != '0) begin
          strb.shift = 1'b1;
        end
      end
      STORE: begin
        strb.store = 1'b1;
        nextState  = RELOAD;
      end
      RELOAD: begin
        if (!txEmpty) begin
          strb.load = 1'b1;
          nextState = READY;
        end else begin
          strb.starve = 1'b1;
          nextState   = IDLE;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      bitCnt <= '0;
    end else begin
      state <= nextState;
      if (state != READY || !selected) bitCnt <= '0;
      else if (rise) bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spiSlaveDatapath.sv
module spiSlaveDatapath
  import spiSlavePkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spiStrobes_t           strb,
  input  logic                  mosiBit,
  input  logic [1:0]            regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [FRAME_BITS-1:0] regWdata,
  output logic [FRAME_BITS-1:0] regRdata,
  output logic                  misoOut,
  output logic                  irqOut,
  output logic                  active,
  output logic                  txEmpty,
  output logic                  rxFull
);
  localparam int FB = FRAME_BITS;

  logic enBit, slaveBit, gieBit;
  logic [2:0] irqFlags, flagSet, flagClr;
  logic [FB-1:0] txHead, rxHead, txHold, txShift, rxShift;
  logic txFull, rxEmpty, txPush, rxPop;

  assign txPush = regWr && regAddr == ADDR_DATA;
  assign rxPop  = regRd && regAddr == ADDR_DATA && !rxEmpty;

  spiSlaveFifo #(.WIDTH(FB), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .din(regWdata),
    .pop(strb.load), .dout(txHead), .empty(txEmpty), .full(txFull)
  );

  spiSlaveFifo #(.WIDTH(FB), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(strb.store), .din(rxShift),
    .pop(rxPop), .dout(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.load) begin
        txHold  <= txHead;
        txShift <= txHead;
      end else if (strb.restore) begin
        txShift <= txHold;
      end else if (strb.shift) begin
        txShift <= {txShift[FB-2:0], 1'b0};
      end
      if (strb.sample) rxShift <= {rxShift[FB-2:0], mosiBit};
    end
  end

  always_comb begin
    flagSet = '0;
    flagSet[FLAG_STARVE]  = strb.starve;
    flagSet[FLAG_OVERRUN] = strb.store && rxFull;
    flagSet[FLAG_STORED]  = strb.store && !rxFull;
    flagClr = (regWr && regAddr == ADDR_FLAG) ? regWdata[2:0] : 3'b000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      slaveBit <= 1'b0;
      gieBit   <= 1'b0;
      irqFlags <= '0;
    end else begin
      if (regWr && regAddr == ADDR_CTRL) begin
        enBit    <= regWdata[0];
        slaveBit <= regWdata[1];
        gieBit   <= regWdata[2];
      end
      irqFlags <= (irqFlags & ~flagClr) | flagSet;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: regRdata[2:0] = {gieBit, slaveBit, enBit};
      ADDR_STAT: regRdata[3:0] = {txFull, txEmpty, rxFull, rxEmpty};
      ADDR_FLAG: regRdata[2:0] = irqFlags;
      default:   regRdata      = rxEmpty ? '0 : rxHead;
    endcase
  end

  assign active  = enBit && slaveBit;
  assign irqOut  = gieBit && (irqFlags != '0);
  assign misoOut = txShift[FB-1];
endmodule

// File: rtl/spiByteSlave.sv
module spiByteSlave
  import spiSlavePkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sckIn,
  input  logic                  mosiIn,
  input  logic                  csnIn,
  output logic                  misoOut,
  input  logic [1:0]            regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [FRAME_BITS-1:0] regWdata,
  output logic [FRAME_BITS-1:0] regRdata,
  output logic                  irqOut
);
  spiStrobes_t strb;
  logic mosiBit, active, txEmpty, rxFull;

  spiSlaveCtrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .csnIn(csnIn),
    .active(active), .txEmpty(txEmpty), .mosiBit(mosiBit), .strb(strb)
  );

  spiSlaveDatapath #(.FRAME_BITS(FRAME_BITS), .FIFO_DEPTH(FIFO_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .misoOut(misoOut), .irqOut(irqOut),
    .active(active), .txEmpty(txEmpty), .rxFull(rxFull)
  );
endmodule

// File: rtl/spiByteSlaveChk.sv
module spiByteSlaveChk
  import spiSlavePkg::*;
(
  input logic        clk,
  input logic        rstN,
  input spiStrobes_t strb,
  input logic        csnS,
  input logic        active,
  input logic        rxFull,
  input logic        txEmpty,
  input logic [2:0]  flags,
  input logic        gie,
  input logic        irqOut
);
  // R3
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csnS |-> !(strb.sample || strb.shift));

  // R4
  inactive_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !strb.sample);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sample, strb.shift, strb.load, strb.store, strb.starve}));

  // R6
  starve_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.starve |=> flags[FLAG_STARVE]);

  // R6
  starve_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.starve |-> txEmpty);

  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.store && rxFull) |=> flags[FLAG_OVERRUN]);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.store && gie && !(rxFull && !flags[FLAG_OVERRUN]) && $stable(gie)) |=> irqOut);
endmodule

bind spiByteSlave spiByteSlaveChk i_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .csnS(i_ctrl.csnS), .active(active),
  .rxFull(rxFull), .txEmpty(txEmpty), .flags(i_dp.irqFlags),
  .gie(i_dp.gieBit), .irqOut(irqOut)
);

// File: tb/test_spiByteSlave.sv
module test_spiByteSlave;
  localparam int HALF = 6;
  localparam int GAP  = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1, miso;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] misoQ[$];
  logic [7:0] rxQ[$];

  always #2 clk = ~clk;

  spiByteSlave i_spiByteSlave (
    .clk(clk), .rstN(rstN), .sckIn(sck), .mosiIn(mosi), .csnIn(csn),
    .misoOut(miso), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irq)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic expectReg(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    regRead(a, d);
    check(d == exp, req, d, exp);
  endtask

  // driver: host writes a byte and, if it should go out, queues it for the MISO monitor
  task automatic hostPush(input logic [7:0] b, input bit expectSent);
    regWrite(2'd3, b);
    if (expectSent) misoQ.push_back(b);
  endtask

  task automatic sckBits(input logic [7:0] b, input int nBits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      got[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  // frame plus monitor: compare MISO against queued byte, queue expected receive byte
  task automatic xfer(input logic [7:0] b, input bit chkMiso, input bit stored, input string req);
    logic [7:0] got, exp;
    sckBits(b, 8, got);
    if (chkMiso) begin
      exp = (misoQ.size() != 0) ? misoQ.pop_front() : 8'hxx;
      check(got === exp, req, got, exp);
    end
    if (stored) rxQ.push_back(b);
  endtask

  task automatic drainRx(input int n, input string req);
    logic [7:0] d, exp;
    for (int i = 0; i < n; i++) begin
      regRead(2'd3, d);
      exp = (rxQ.size() != 0) ? rxQ.pop_front() : 8'hxx;
      check(d === exp, req, d, exp);
    end
  endtask

  initial begin
    logic [7:0] dummy;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expectReg(2'd0, 8'h00, "R1 ctrl");
    expectReg(2'd1, 8'h05, "R1 status");
    expectReg(2'd2, 8'h00, "R1 flags");
    check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);

    // R4 enable without slave mode: frame ignored, nothing loaded
    regWrite(2'd0, 8'h01);
    hostPush(8'hA5, 1'b1);
    csn = 1'b0;
    repeat (8) @(negedge clk);
    xfer(8'h3C, 1'b0, 1'b0, "R4");
    expectReg(2'd1, 8'h01, "R4 status");

    // R2 full enable: byte exchanged
    regWrite(2'd0, 8'h07);
    repeat (6) @(negedge clk);
    xfer(8'h3C, 1'b1, 1'b1, "R2 miso");
    expectReg(2'd2, 8'h05, "R6 starve+stored flags");
    check(irq == 1'b1, "R9 irq set", {7'd0, irq}, 8'h01);
    drainRx(1, "R2 rx byte");

    // R6 halted: frame ignored
    xfer(8'h11, 1'b0, 1'b0, "R6");
    expectReg(2'd1, 8'h05, "R6 halted status");

    // R9 write-one-to-clear
    regWrite(2'd2, 8'h02);
    expectReg(2'd2, 8'h05, "R9 partial clear");
    regWrite(2'd2, 8'h07);
    expectReg(2'd2, 8'h00, "R9 clear");
    check(irq == 1'b0, "R9 irq clear", {7'd0, irq}, 8'h00);

    // R5 ordering and automatic reload
    hostPush(8'h01, 1'b1);
    hostPush(8'h02, 1'b1);
    hostPush(8'h03, 1'b1);
    repeat (4) @(negedge clk);
    xfer(8'hF0, 1'b1, 1'b1, "R5 miso0");
    xfer(8'h0F, 1'b1, 1'b1, "R5 miso1");
    xfer(8'h99, 1'b1, 1'b1, "R5 miso2");
    drainRx(3, "R5 rx order");
    expectReg(2'd1, 8'h05, "R5 status");
    regWrite(2'd2, 8'h07);

    // R3 abort mid-frame by deselect
    hostPush(8'hC3, 1'b1);
    hostPush(8'h5A, 1'b1);
    repeat (4) @(negedge clk);
    sckBits(8'hFF, 3, dummy);
    csn = 1'b1;
    repeat (10) @(negedge clk);
    xfer(8'h66, 1'b0, 1'b0, "R3 deselected");
    expectReg(2'd1, 8'h01, "R3 nothing stored while deselected");
    csn = 1'b0;
    repeat (10) @(negedge clk);
    xfer(8'h77, 1'b1, 1'b1, "R3 resent byte");
    expectReg(2'd1, 8'h04, "R3 one byte stored");
    xfer(8'h12, 1'b1, 1'b1, "R3 next byte");
    drainRx(2, "R3 rx");
    regWrite(2'd2, 8'h07);

    // R7 depth and dropped write, R8 overrun
    regWrite(2'd0, 8'h00);
    for (int i = 0; i < 17; i++) hostPush(8'h40 + 8'(i), i < 16);
    expectReg(2'd1, 8'h09, "R7 tx full");
    regWrite(2'd0, 8'h03);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) xfer(8'h80 + 8'(i), 1'b1, 1'b1, "R7 miso");
    expectReg(2'd1, 8'h06, "R7 rx full");
    hostPush(8'hEE, 1'b1);
    repeat (4) @(negedge clk);
    xfer(8'h55, 1'b1, 1'b0, "R8 miso");
    expectReg(2'd2, 8'h07, "R8 overrun flag");
    check(irq == 1'b0, "R9 gated irq", {7'd0, irq}, 8'h00);
    regWrite(2'd0, 8'h07);
    check(irq == 1'b1, "R9 ungated irq", {7'd0, irq}, 8'h01);
    drainRx(16, "R8 kept bytes");
    expectReg(2'd1, 8'h05, "R8 drained status");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule